// File: doc/BRIEF.md
# Multi-Way Translation Lookaside Buffer with Ring Mapping

This block translates a virtual address to a physical address by comparing it against every way of a small translation buffer in parallel. Each way has its own page size and holds a few entries, each made of a virtual page base, a physical page base, an 8-bit address-space identifier and a 4-bit attribute code. An entry only counts as a hit when its identifier appears in the ring-mapping register. The byte position where the identifier is found gives the privilege ring that owns the page. The result of a lookup is either a physical address with the granted rights and cache mode, or a fault code.

One parameter picks the side. An instruction-side instance treats every request as a fetch. A data-side instance treats a request as a load or a store, depending on the write flag. Entries are loaded through a synchronous write port, either into a named way or into the way chosen by the rotating refill pointer. The table walk that produces a refill is not part of this block: a miss is only reported.

Requests use valid/ready. The result sits in a single output register and is valid one cycle after a request is accepted. `req_ready` is high when that register is empty or is being drained in the same cycle (`res_ready` high). While `res_valid` is high and `res_ready` is low, the result holds steady and no new request is taken. The write port and the ring-register port are plain controls that act on every clock where their enable is high.

Top module: `tlbr_lookup`

## Requirements
- R1: After reset, the ring register holds 0x04030201, every entry holds identifier 0, `res_valid` is 0 and `req_ready` is 1. Every lookup made before any entry write reports a miss.
- R2: A way hits when all of these hold: the stored page base equals the address with that way's offset bits cleared; the stored identifier is nonzero; the identifier equals some byte of the ring register. The ring is the lowest byte index that matches. Byte 0 is bits [7:0] and maps to ring 0.
- R3: When more than one way hits, the fault is the multi-hit code: 2 on the instruction side, 6 on the data side. This check comes before every other check.
- R4: When no way hits, the fault is the miss code: 1 on the instruction side, 5 on the data side.
- R5: On a single hit whose ring is numerically below `req_ring`, the fault is the privilege code: 3 on the instruction side, 7 on the data side.
- R6: Attribute values below 12 grant read. Attribute bit 0 adds execute and bit 1 adds write. `res_cache` is taken from attribute bits [3:2]: 0 is bypass, 1 is write-back, 2 is write-through.
- R7: Attribute 13 grants read and write with `res_cache` = 3 (isolate). The values 12, 14 and 15 grant nothing.
- R8: `res_rights` is {execute, write, read}. The instruction side keeps only execute and the data side drops execute. When the needed right is missing, the fault is 4 for a fetch, 8 for a load and 9 for a store. A fault code of 0 means success.
- R9: Ways below SMALL_WAYS use pages of 2^SMALL_SHIFT bytes; the other ways use 2^LARGE_SHIFT. The entry index is the IDX_W address bits just above the offset. The physical address is the stored physical base ORed with the address offset bits.
- R10: A write with `wr_auto` set first increments the refill pointer and then uses its low two bits as the way. After reset the refill ways run 1, 2, 3, 0, 1, and so on.
- R11: A result appears one cycle after the request is accepted. `req_ready` equals `!res_valid || res_ready`. A held result stays stable.
- R12: A lookup sees the entries and the ring register as they stood before any write in the same cycle.
- R13: A faulting result carries zero physical address, rights, cache mode and ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted when high |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_write | input | 1 | Data side: 1 store, 0 load; ignored on instruction side |
| req_ring | input | 2 | Current privilege ring of the requester |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_fault | output | 4 | Fault code, 0 on success |
| res_paddr | output | VA_W | Translated physical address |
| res_rights | output | 3 | Granted {execute, write, read} |
| res_cache | output | 2 | Cache mode of the page |
| res_ring | output | 2 | Ring owning the page |
| wr_en | input | 1 | Entry write enable |
| wr_auto | input | 1 | Use refill pointer instead of wr_way |
| wr_way | input | WAY_W | Target way for a direct write |
| wr_vaddr | input | VA_W | Virtual address giving page base and index |
| wr_paddr | input | VA_W | Physical address giving page base |
| wr_asid | input | ASID_W | Entry identifier |
| wr_attr | input | 4 | Entry attribute code |
| rasid_we | input | 1 | Ring register write enable |
| rasid_wdata | input | 4*ASID_W | New ring register value |

## Verification
The bench drives one instance of each side from the same inputs. It compares both against a behavioural reference on every clock. The address patterns are chosen so that each outcome is told apart from the others:
- exact page hits compared with pages that differ only in the index bits;
- an identifier that is absent from the ring register, and then present after the register is rewritten, including a value that appears in several bytes;
- one page loaded into two ways, to expose a wrong precedence between multi-hit and success;
- a large-page way, where the offset mask would give the wrong physical address if the page size were mixed up.

Every attribute class is tried under fetch, load and store, so the side masks and the prohibited codes are separated. The refill pointer is checked by a direct write to the way the pointer should have picked: a wrong pick shows up as a multi-hit or an old physical address. The bench also stalls the consumer during a burst of requests, and puts a write and a lookup of the same entry in one cycle.

// File: rtl/tlbr_pkg.sv
`timescale 1ns/1ps
package tlbr_pkg;

  typedef enum logic [3:0] {
    CZ_OK        = 4'd0,
    CZ_F_MISS    = 4'd1,
    CZ_F_MULTI   = 4'd2,
    CZ_F_PRIV    = 4'd3,
    CZ_F_PROHIB  = 4'd4,
    CZ_D_MISS    = 4'd5,
    CZ_D_MULTI   = 4'd6,
    CZ_D_PRIV    = 4'd7,
    CZ_LD_PROHIB = 4'd8,
    CZ_ST_PROHIB = 4'd9
  } cause_e;

  typedef enum logic [1:0] {
    CM_BYPASS  = 2'd0,
    CM_WBACK   = 2'd1,
    CM_WTHRU   = 2'd2,
    CM_ISOLATE = 2'd3
  } cache_e;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } rights_t;

  localparam int unsigned ATTR_W = 4;
  localparam int unsigned NRING  = 4;
  localparam int unsigned RING_W = 2;

endpackage

// File: rtl/tlbr_way.sv
`timescale 1ns/1ps
module tlbr_way #(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned IDX_W  = 2,
  parameter int unsigned SHIFT  = 12,
  parameter int unsigned ASID_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [VA_W-1:0]               wr_vaddr,
  input  logic [VA_W-1:0]               wr_paddr,
  input  logic [ASID_W-1:0]             wr_asid,
  input  logic [tlbr_pkg::ATTR_W-1:0]   wr_attr,
  input  logic [VA_W-1:0]               lk_vaddr,
  output logic                          rd_match,
  output logic [ASID_W-1:0]             rd_asid,
  output logic [tlbr_pkg::ATTR_W-1:0]   rd_attr,
  output logic [VA_W-1:0]               rd_pbase,
  output logic [VA_W-1:0]               rd_mask
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam logic [VA_W-1:0] OFF_MASK = VA_W'((64'd1 << SHIFT) - 64'd1);

  logic [VA_W-1:0]             vb_q   [DEPTH];
  logic [VA_W-1:0]             pb_q   [DEPTH];
  logic [ASID_W-1:0]           asid_q [DEPTH];
  logic [tlbr_pkg::ATTR_W-1:0] attr_q [DEPTH];

  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] lk_idx;

  assign wr_idx = wr_vaddr[SHIFT +: IDX_W];
  assign lk_idx = lk_vaddr[SHIFT +: IDX_W];

  // Entry storage; identifier 0 marks an empty slot (R1)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        vb_q[i]   <= '0;
        pb_q[i]   <= '0;
        asid_q[i] <= '0;
        attr_q[i] <= '0;
      end
    end else if (wr_en) begin
      vb_q[wr_idx]   <= wr_vaddr & ~OFF_MASK;
      pb_q[wr_idx]   <= wr_paddr & ~OFF_MASK;
      asid_q[wr_idx] <= wr_asid;
      attr_q[wr_idx] <= wr_attr;
    end
  end

  // Page compare against this way's own page size (R2, R9)
  assign rd_match = ((lk_vaddr & ~OFF_MASK) == vb_q[lk_idx]) && (asid_q[lk_idx] != '0);
  assign rd_asid  = asid_q[lk_idx];
  assign rd_attr  = attr_q[lk_idx];
  assign rd_pbase = pb_q[lk_idx];
  assign rd_mask  = OFF_MASK;

endmodule

// File: rtl/tlbr_ring_map.sv
`timescale 1ns/1ps
module tlbr_ring_map #(
  parameter int unsigned ASID_W = 8
) (
  input  logic [tlbr_pkg::NRING*ASID_W-1:0] rasid,
  input  logic [ASID_W-1:0]                 asid,
  output logic                              found,
  output logic [tlbr_pkg::RING_W-1:0]       ring
);
  // Scan from the top byte down so the lowest matching byte wins (R2)
  always_comb begin
    found = 1'b0;
    ring  = '0;
    for (int b = tlbr_pkg::NRING - 1; b >= 0; b--) begin
      if (rasid[b*ASID_W +: ASID_W] == asid) begin
        found = 1'b1;
        ring  = tlbr_pkg::RING_W'(b);
      end
    end
  end
endmodule

// File: rtl/tlbr_attr_decode.sv
`timescale 1ns/1ps
module tlbr_attr_decode
  import tlbr_pkg::*;
(
  input  logic [ATTR_W-1:0] attr,
  output rights_t           rights,
  output cache_e            cache
);
  // R6, R7: attribute code to rights and cache mode
  always_comb begin
    rights = '0;
    cache  = CM_BYPASS;
    if (attr < 4'd12) begin
      rights.r = 1'b1;
      rights.x = attr[0];
      rights.w = attr[1];
      cache    = cache_e'(attr[3:2]);
    end else if (attr == 4'd13) begin
      rights.r = 1'b1;
      rights.w = 1'b1;
      cache    = CM_ISOLATE;
    end
  end
endmodule

// File: rtl/tlbr_refill_ptr.sv
`timescale 1ns/1ps
module tlbr_refill_ptr #(
  parameter int unsigned PTR_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bump,
  output logic [1:0] next_way
);
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_inc;

  // Increment first, then the low two bits pick the way (R10)
  assign ptr_inc  = ptr_q + PTR_W'(1);
  assign next_way = ptr_inc[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else if (bump) ptr_q <= ptr_inc;
  end

  a_r10_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    bump |=> ptr_q == $past(ptr_q) + PTR_W'(1));

  a_r10_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bump |=> $stable(ptr_q));
endmodule

// File: rtl/tlbr_lookup.sv
`timescale 1ns/1ps
module tlbr_lookup
  import tlbr_pkg::*;
#(
  parameter int unsigned VA_W        = 32,
  parameter int unsigned NWAYS       = 6,
  parameter int unsigned IDX_W       = 2,
  parameter int unsigned SMALL_WAYS  = 4,
  parameter int unsigned SMALL_SHIFT = 12,
  parameter int unsigned LARGE_SHIFT = 20,
  parameter int unsigned ASID_W      = 8,
  parameter int unsigned PTR_W       = 8,
  parameter bit          IS_DATA     = 1'b1,
  localparam int unsigned WAY_W      = $clog2(NWAYS),
  localparam int unsigned RAS_W      = NRING * ASID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  input  logic [1:0]        req_ring,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [3:0]        res_fault,
  output logic [VA_W-1:0]   res_paddr,
  output logic [2:0]        res_rights,
  output logic [1:0]        res_cache,
  output logic [1:0]        res_ring,
  input  logic              wr_en,
  input  logic              wr_auto,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [VA_W-1:0]   wr_vaddr,
  input  logic [VA_W-1:0]   wr_paddr,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [3:0]        wr_attr,
  input  logic              rasid_we,
  input  logic [RAS_W-1:0]  rasid_wdata
);
  localparam int unsigned CNT_W = $clog2(NWAYS + 1);

  function automatic logic [RAS_W-1:0] rasid_init();
    logic [RAS_W-1:0] v;
    v = '0;
    for (int b = 0; b < NRING; b++) v[b*ASID_W +: ASID_W] = ASID_W'(b + 1);
    return v;
  endfunction
  localparam logic [RAS_W-1:0] RASID_RST = rasid_init();

  // Ring register (R1, R12)
  logic [RAS_W-1:0] rasid_q;
  always_ff @(posedge clk) begin
    if (!rst_n) rasid_q <= RASID_RST;
    else if (rasid_we) rasid_q <= rasid_wdata;
  end

  // Refill pointer and write target (R10)
  logic [1:0]       auto_way;
  logic [WAY_W-1:0] tgt_way;

  tlbr_refill_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .bump(wr_en && wr_auto), .next_way(auto_way)
  );
  assign tgt_way = wr_auto ? WAY_W'(auto_way) : wr_way;

  // Parallel ways
  logic [NWAYS-1:0]   w_match;
  logic [NWAYS-1:0]   w_found;
  logic [NWAYS-1:0]   hit;
  logic [RING_W-1:0]  w_ring  [NWAYS];
  logic [ASID_W-1:0]  w_asid  [NWAYS];
  logic [ATTR_W-1:0]  w_attr  [NWAYS];
  logic [VA_W-1:0]    w_pbase [NWAYS];
  logic [VA_W-1:0]    w_mask  [NWAYS];

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    localparam int unsigned WSH = (w < SMALL_WAYS) ? SMALL_SHIFT : LARGE_SHIFT;

    tlbr_way #(.VA_W(VA_W), .IDX_W(IDX_W), .SHIFT(WSH), .ASID_W(ASID_W)) u_way (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en && (tgt_way == WAY_W'(w))),
      .wr_vaddr(wr_vaddr), .wr_paddr(wr_paddr), .wr_asid(wr_asid), .wr_attr(wr_attr),
      .lk_vaddr(req_vaddr),
      .rd_match(w_match[w]), .rd_asid(w_asid[w]), .rd_attr(w_attr[w]),
      .rd_pbase(w_pbase[w]), .rd_mask(w_mask[w])
    );

    tlbr_ring_map #(.ASID_W(ASID_W)) u_ring (
      .rasid(rasid_q), .asid(w_asid[w]), .found(w_found[w]), .ring(w_ring[w])
    );

    assign hit[w] = w_match[w] && w_found[w];
  end

  // Hit count and selection of the single hitting way
  logic [CNT_W-1:0]  hit_cnt;
  logic [RING_W-1:0] sel_ring;
  logic [ATTR_W-1:0] sel_attr;
  logic [VA_W-1:0]   sel_pbase;
  logic [VA_W-1:0]   sel_mask;

  assign hit_cnt = CNT_W'($countones(hit));

  always_comb begin
    sel_ring  = '0;
    sel_attr  = '0;
    sel_pbase = '0;
    sel_mask  = '0;
    for (int w = NWAYS - 1; w >= 0; w--) begin
      if (hit[w]) begin
        sel_ring  = w_ring[w];
        sel_attr  = w_attr[w];
        sel_pbase = w_pbase[w];
        sel_mask  = w_mask[w];
      end
    end
  end

  rights_t dec_rights;
  cache_e  dec_cache;
  tlbr_attr_decode u_dec (.attr(sel_attr), .rights(dec_rights), .cache(dec_cache));

  // Side mask and permission check (R8)
  rights_t side_rights;
  logic    need_ok;
  always_comb begin
    side_rights = dec_rights;
    if (IS_DATA) side_rights.x = 1'b0;
    else begin
      side_rights.r = 1'b0;
      side_rights.w = 1'b0;
    end
    if (IS_DATA) need_ok = req_write ? side_rights.w : side_rights.r;
    else         need_ok = side_rights.x;
  end

  // Fault precedence: multi-hit, miss, privilege, prohibited (R3, R4, R5, R8, R13)
  cause_e            nx_fault;
  logic [VA_W-1:0]   nx_paddr;
  logic [2:0]        nx_rights;
  logic [1:0]        nx_cache;
  logic [RING_W-1:0] nx_ring;
  always_comb begin
    nx_paddr  = '0;
    nx_rights = '0;
    nx_cache  = '0;
    nx_ring   = '0;
    if (hit_cnt > CNT_W'(1))       nx_fault = IS_DATA ? CZ_D_MULTI : CZ_F_MULTI;
    else if (hit_cnt == '0)        nx_fault = IS_DATA ? CZ_D_MISS  : CZ_F_MISS;
    else if (sel_ring < req_ring)  nx_fault = IS_DATA ? CZ_D_PRIV  : CZ_F_PRIV;
    else if (!need_ok) begin
      if (IS_DATA) nx_fault = req_write ? CZ_ST_PROHIB : CZ_LD_PROHIB;
      else         nx_fault = CZ_F_PROHIB;
    end else begin
      nx_fault  = CZ_OK;
      nx_paddr  = sel_pbase | (req_vaddr & sel_mask);
      nx_rights = side_rights;
      nx_cache  = dec_cache;
      nx_ring   = sel_ring;
    end
  end

  // Registered result stage (R11)
  logic accept;
  assign req_ready = !res_valid || res_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_fault  <= '0;
      res_paddr  <= '0;
      res_rights <= '0;
      res_cache  <= '0;
      res_ring   <= '0;
    end else if (accept) begin
      res_valid  <= 1'b1;
      res_fault  <= nx_fault;
      res_paddr  <= nx_paddr;
      res_rights <= nx_rights;
      res_cache  <= nx_cache;
      res_ring   <= nx_ring;
    end else if (res_ready) begin
      res_valid  <= 1'b0;
    end
  end

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_fault) && $stable(res_paddr)
                                   && $stable(res_rights)));

  a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> res_valid);

  a_r13_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault != 4'd0) |-> (res_paddr == '0 && res_rights == '0 && res_ring == '0));

  a_r3_multi_first: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit_cnt > CNT_W'(1)) |=> (res_fault == (IS_DATA ? 4'd6 : 4'd2)));

  a_r8_side_mask: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (IS_DATA ? !res_rights[2] : (res_rights[1:0] == 2'b00)));

endmodule

// File: tb/tlbr_lookup_bench.sv
`timescale 1ns/1ps
module tlbr_lookup_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_ring = '0;
  logic        res_ready = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_auto = 1'b0;
  logic [2:0]  wr_way = '0;
  logic [31:0] wr_vaddr = '0;
  logic [31:0] wr_paddr = '0;
  logic [7:0]  wr_asid = '0;
  logic [3:0]  wr_attr = '0;
  logic        rasid_we = 1'b0;
  logic [31:0] rasid_wdata = '0;

  logic        rdy   [2];
  logic        vld   [2];
  logic [3:0]  flt   [2];
  logic [31:0] pad   [2];
  logic [2:0]  rts   [2];
  logic [1:0]  cch   [2];
  logic [1:0]  rng   [2];

  always #2.5 clk = ~clk;

  // Index 0: instruction side, index 1: data side
  tlbr_lookup #(.IS_DATA(1'b0)) u_tlbr_lookup_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[0]),
    .req_vaddr(req_vaddr), .req_write(req_write), .req_ring(req_ring),
    .res_valid(vld[0]), .res_ready(res_ready), .res_fault(flt[0]), .res_paddr(pad[0]),
    .res_rights(rts[0]), .res_cache(cch[0]), .res_ring(rng[0]),
    .wr_en(wr_en), .wr_auto(wr_auto), .wr_way(wr_way), .wr_vaddr(wr_vaddr),
    .wr_paddr(wr_paddr), .wr_asid(wr_asid), .wr_attr(wr_attr),
    .rasid_we(rasid_we), .rasid_wdata(rasid_wdata)
  );

  tlbr_lookup #(.IS_DATA(1'b1)) u_tlbr_lookup (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[1]),
    .req_vaddr(req_vaddr), .req_write(req_write), .req_ring(req_ring),
    .res_valid(vld[1]), .res_ready(res_ready), .res_fault(flt[1]), .res_paddr(pad[1]),
    .res_rights(rts[1]), .res_cache(cch[1]), .res_ring(rng[1]),
    .wr_en(wr_en), .wr_auto(wr_auto), .wr_way(wr_way), .wr_vaddr(wr_vaddr),
    .wr_paddr(wr_paddr), .wr_asid(wr_asid), .wr_attr(wr_attr),
    .rasid_we(rasid_we), .rasid_wdata(rasid_wdata)
  );

  // Reference model state
  logic [31:0] m_vb [6][4];
  logic [31:0] m_pb [6][4];
  logic [7:0]  m_as [6][4];
  logic [3:0]  m_at [6][4];
  logic [31:0] m_rasid;
  int          m_ptr;
  logic        e_valid [2];
  logic [3:0]  e_fault [2];
  logic [31:0] e_paddr [2];
  logic [2:0]  e_rts   [2];
  logic [1:0]  e_cch   [2];
  logic [1:0]  e_rng   [2];

  int    nchk = 0;
  int    nfail = 0;
  string cur_req = "R1";

  function automatic int wshift(input int w);
    return (w < 4) ? 12 : 20;
  endfunction

  function automatic void mlook(input int side, input logic [31:0] va, input logic wr,
                                input logic [1:0] cr, output logic [3:0] f,
                                output logic [31:0] pa, output logic [2:0] rt,
                                output logic [1:0] cm, output logic [1:0] rg);
    int nh;
    int hw;
    int hi;
    int hr;
    nh = 0; hw = 0; hi = 0; hr = 0;
    f = 0; pa = 0; rt = 0; cm = 0; rg = 0;
    for (int w = 0; w < 6; w++) begin
      logic [31:0] msk;
      int i;
      int r;
      msk = (32'd1 << wshift(w)) - 32'd1;
      i = int'((va >> wshift(w)) & 32'd3);
      r = -1;
      if (((va & ~msk) == m_vb[w][i]) && (m_as[w][i] != 8'd0)) begin
        for (int b = 3; b >= 0; b--) if (m_rasid[8*b +: 8] == m_as[w][i]) r = b;
        if (r >= 0) begin
          nh++;
          if (nh == 1) begin hw = w; hi = i; hr = r; end
        end
      end
    end
    if (nh > 1) f = (side == 1) ? 4'd6 : 4'd2;
    else if (nh == 0) f = (side == 1) ? 4'd5 : 4'd1;
    else if (hr < int'(cr)) f = (side == 1) ? 4'd7 : 4'd3;
    else begin
      logic [3:0] a;
      logic rr;
      logic ww;
      logic xx;
      logic need;
      logic [1:0] c;
      a = m_at[hw][hi];
      rr = 0; ww = 0; xx = 0; c = 0;
      if (a < 4'd12) begin rr = 1; xx = a[0]; ww = a[1]; c = a[3:2]; end
      else if (a == 4'd13) begin rr = 1; ww = 1; c = 2'd3; end
      if (side == 1) xx = 0;
      else begin rr = 0; ww = 0; end
      need = (side == 1) ? (wr ? ww : rr) : xx;
      if (!need) f = (side == 1) ? (wr ? 4'd9 : 4'd8) : 4'd4;
      else begin
        pa = m_pb[hw][hi] | (va & ((32'd1 << wshift(hw)) - 32'd1));
        rt = {xx, ww, rr};
        cm = c;
        rg = 2'(hr);
      end
    end
  endfunction

  task automatic model_step();
    if (!rst_n) begin
      for (int w = 0; w < 6; w++)
        for (int i = 0; i < 4; i++) begin
          m_vb[w][i] = 0; m_pb[w][i] = 0; m_as[w][i] = 0; m_at[w][i] = 0;
        end
      m_rasid = 32'h04030201;
      m_ptr = 0;
      for (int s = 0; s < 2; s++) begin
        e_valid[s] = 0; e_fault[s] = 0; e_paddr[s] = 0; e_rts[s] = 0; e_cch[s] = 0; e_rng[s] = 0;
      end
    end else begin
      for (int s = 0; s < 2; s++) begin
        logic ok_in;
        ok_in = !e_valid[s] || res_ready;
        if (req_valid && ok_in) begin
          mlook(s, req_vaddr, req_write, req_ring, e_fault[s], e_paddr[s], e_rts[s],
                e_cch[s], e_rng[s]);
          e_valid[s] = 1;
        end else if (res_ready) e_valid[s] = 0;
      end
      if (wr_en) begin
        int w;
        int i;
        logic [31:0] msk;
        if (wr_auto) begin m_ptr = m_ptr + 1; w = m_ptr % 4; end
        else w = int'(wr_way);
        msk = (32'd1 << wshift(w)) - 32'd1;
        i = int'((wr_vaddr >> wshift(w)) & 32'd3);
        m_vb[w][i] = wr_vaddr & ~msk;
        m_pb[w][i] = wr_paddr & ~msk;
        m_as[w][i] = wr_asid;
        m_at[w][i] = wr_attr;
      end
      if (rasid_we) m_rasid = rasid_wdata;
    end
  endtask

  task automatic chk(input int s, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s side=%0d %s actual=%h expected=%h", cur_req, s, what, act, exp);
    end
  endtask

  task automatic compare();
    for (int s = 0; s < 2; s++) begin
      chk(s, "req_ready R11", 32'(rdy[s]), 32'(!e_valid[s] || res_ready));
      chk(s, "res_valid R11", 32'(vld[s]), 32'(e_valid[s]));
      if (e_valid[s]) begin
        chk(s, "fault", 32'(flt[s]), 32'(e_fault[s]));
        chk(s, "paddr", pad[s], e_paddr[s]);
        chk(s, "rights", 32'(rts[s]), 32'(e_rts[s]));
        chk(s, "cache", 32'(cch[s]), 32'(e_cch[s]));
        chk(s, "ring", 32'(rng[s]), 32'(e_rng[s]));
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    model_step();
    compare();
  endtask

  task automatic quiet();
    req_valid = 0; wr_en = 0; wr_auto = 0; rasid_we = 0;
  endtask

  task automatic put(input int way, input logic auto_sel, input logic [31:0] va,
                     input logic [31:0] pa, input logic [7:0] asid, input logic [3:0] attr);
    wr_en = 1; wr_auto = auto_sel; wr_way = 3'(way);
    wr_vaddr = va; wr_paddr = pa; wr_asid = asid; wr_attr = attr;
    tick();
    quiet();
  endtask

  task automatic look(input logic [31:0] va, input logic wr, input logic [1:0] ring);
    req_valid = 1; req_vaddr = va; req_write = wr; req_ring = ring;
    tick();
    quiet();
    tick();
  endtask

  task automatic set_rasid(input logic [31:0] v);
    rasid_we = 1; rasid_wdata = v;
    tick();
    quiet();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    // R1: reset state and empty table
    cur_req = "R1";
    repeat (3) tick();
    rst_n = 1;
    tick();
    look(32'h0000_0000, 0, 0);
    look(32'h0000_1234, 0, 0);

    // R2: basic hit, both sides
    cur_req = "R2";
    put(0, 0, 32'h0000_1000, 32'h8000_5000, 8'd1, 4'h3);
    look(32'h0000_1abc, 0, 0);
    look(32'h0000_1abc, 1, 0);
    // R4: neighbouring index misses
    cur_req = "R4";
    look(32'h0000_2abc, 0, 0);

    // R6: attribute classes below 12
    cur_req = "R6";
    put(1, 0, 32'h0000_3000, 32'h9000_0000, 8'd1, 4'h4);
    look(32'h0000_3010, 0, 0);
    look(32'h0000_3010, 1, 0);
    put(2, 0, 32'h0000_4000, 32'h9100_0000, 8'd1, 4'h9);
    look(32'h0000_4020, 0, 0);
    look(32'h0000_4020, 1, 0);
    put(3, 0, 32'h0000_5000, 32'h9200_0000, 8'd1, 4'h6);
    look(32'h0000_5030, 0, 0);
    look(32'h0000_5030, 1, 0);

    // R7: isolate and no-access codes
    cur_req = "R7";
    put(0, 0, 32'h0000_6000, 32'h9300_0000, 8'd1, 4'd13);
    look(32'h0000_6040, 0, 0);
    look(32'h0000_6040, 1, 0);
    put(1, 0, 32'h0000_7000, 32'h9400_0000, 8'd1, 4'd12);
    look(32'h0000_7050, 0, 0);
    put(2, 0, 32'h0000_8000, 32'h9500_0000, 8'd1, 4'd15);
    look(32'h0000_8060, 1, 0);

    // R5: privilege against ring 1 page
    cur_req = "R5";
    put(3, 0, 32'h0000_9000, 32'hA000_0000, 8'd2, 4'h3);
    look(32'h0000_9004, 0, 2);
    look(32'h0000_9004, 0, 1);
    look(32'h0000_9004, 0, 0);
    look(32'h0000_9004, 1, 3);

    // R2: identifier must be present; lowest byte gives ring
    cur_req = "R2";
    put(2, 0, 32'h0000_A000, 32'hA100_0000, 8'd9, 4'h3);
    look(32'h0000_A008, 0, 0);
    set_rasid(32'h0202_0209);
    look(32'h0000_A008, 0, 0);
    look(32'h0000_9004, 0, 1);
    // R12: ring write and lookup in the same cycle use the old value
    cur_req = "R12";
    rasid_we = 1; rasid_wdata = 32'h0403_0201;
    req_valid = 1; req_vaddr = 32'h0000_A008; req_write = 0; req_ring = 0;
    tick();
    quiet();
    tick();
    look(32'h0000_A008, 0, 0);

    // R3: multi-hit, then one copy unmapped
    cur_req = "R3";
    put(0, 0, 32'h0000_B000, 32'hB000_0000, 8'd1, 4'h3);
    put(1, 0, 32'h0000_B000, 32'hB100_0000, 8'd1, 4'h3);
    look(32'h0000_B00C, 0, 0);
    look(32'h0000_B00C, 1, 0);
    put(1, 0, 32'h0000_B000, 32'hB100_0000, 8'd9, 4'h3);
    look(32'h0000_B00C, 0, 0);

    // R9: large page ways
    cur_req = "R9";
    put(4, 0, 32'h1234_5678, 32'hABC0_0000, 8'd3, 4'h3);
    look(32'h123F_FFFF, 0, 2);
    look(32'h1230_0001, 1, 2);
    put(5, 0, 32'h0010_0000, 32'h0770_0000, 8'd1, 4'h1);
    look(32'h0018_8888, 0, 0);
    look(32'h0020_0000, 0, 0);

    // R10: refill pointer 1,2,3,0,1; direct write to expected way must overwrite
    cur_req = "R10";
    for (int k = 0; k < 5; k++) begin
      logic [31:0] va;
      int expw;
      va = 32'h0000_C000 + 32'(k) * 32'h0001_0000;
      expw = (k + 1) % 4;
      put(0, 1, va, 32'h1000_0000, 8'd1, 4'h3);
      put(expw, 0, va, 32'h2000_0000 + 32'(k) * 32'h1000, 8'd1, 4'h3);
      look(va + 32'h10, 0, 0);
    end

    // R11: back-pressure burst
    cur_req = "R11";
    res_ready = 0;
    req_valid = 1; req_write = 0; req_ring = 0;
    req_vaddr = 32'h0000_1abc; tick();
    req_vaddr = 32'h0000_3010; tick();
    req_vaddr = 32'h0000_5030; tick();
    res_ready = 1; tick();
    req_vaddr = 32'h0000_4020; tick();
    quiet();
    tick();
    tick();

    // R12: entry write and lookup in the same cycle
    cur_req = "R12";
    wr_en = 1; wr_auto = 0; wr_way = 0; wr_vaddr = 32'h0000_1000;
    wr_paddr = 32'h0; wr_asid = 8'd0; wr_attr = 4'h0;
    req_valid = 1; req_vaddr = 32'h0000_1abc; req_write = 0; req_ring = 0;
    tick();
    quiet();
    tick();
    // R13: faulting result fields are zero (checked on every fault above too)
    cur_req = "R13";
    look(32'h0000_1abc, 0, 0);
    look(32'h0000_1abc, 1, 0);

    finish_run();
  end
endmodule